// File: doc/BRIEF.md
# Big-endian byte and word data memory

This block is the data store behind a processor core's load and store path. The core presents a 32-bit byte address, an access size (a full word or a single byte), a write enable and 32-bit write data. The block returns 32-bit read data. Reads are combinational, so a load gets its data in the same cycle it presents the address. Writes take effect on the rising clock edge.

Storage is organised as words of four byte lanes, and each lane has its own write enable. Bytes are placed in big-endian order: the byte whose address is the word address sits in the most significant lane. A byte load returns the addressed byte in the low eight bits of the result, sign-extended by default. A byte store takes the low eight bits of the write data and changes only the addressed byte. Word accesses must be 4-byte aligned. A word access that is not aligned raises a flag, does not write, and reads as zero.

The depth is a parameter counted in words. The word index is taken from the address bits just above bit 1, so address bits above the index alias onto the same storage.

Top module: `be_data_mem`

## Requirements
- R1: A word store (acc_byte_i = 0, we_i = 1) at an address with addr_i[1:0] = 0 writes all four bytes. A later word load from that address returns the stored 32-bit value.
- R2: Byte order is big-endian. A byte load (acc_byte_i = 1) at byte offset k = addr_i[1:0] returns the bits [31-8k : 24-8k] of the stored word in rdata_o[7:0]. Offset 0 maps to bits [31:24] and offset 3 maps to bits [7:0].
- R3: With BYTE_LOAD_SIGNED = 1 (the default), a byte load copies bit 7 of the selected byte into rdata_o[31:8].
- R4: A byte store writes wdata_i[7:0] into the addressed byte only. The other three bytes of that word are left unchanged.
- R5: misalign_o is 1 exactly when a word access has addr_i[1:0] other than 0. It is 0 for every byte access.
- R6: A misaligned word store does not change memory.
- R7: While misalign_o is 1, rdata_o is zero.
- R8: Reads are combinational: rdata_o follows the address in the same cycle. A write becomes visible only after the rising clock edge that commits it.
- R9: The word index is addr_i[IDX_W+1:2], with IDX_W = log2(DEPTH_WORDS). Higher address bits are ignored, so addresses that differ by a multiple of 4*DEPTH_WORDS reach the same word.
- R10: With we_i = 0, no access changes memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes commit on its rising edge |
| addr_i | input | ADDR_W | Byte address |
| acc_byte_i | input | 1 | Access size: 0 = word, 1 = byte |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Store data; only bits [7:0] are used for a byte store |
| rdata_o | output | 32 | Load data, valid in the same cycle |
| misalign_o | output | 1 | Word access with nonzero low address bits |

## Verification
The checker tests several rules on every cycle. A misaligned access reads as zero and enables no lane. A disabled write enables no lane. Byte accesses never raise the misalign flag. A byte load always has a sign-extended upper part. An aligned word store read back at the same address on the next cycle returns the stored data. Lane isolation for byte stores, the big-endian position of each offset, aliasing of high address bits, and the proof that a suppressed or disabled write left the memory intact all need stored history. Only the bench shows these, by comparing a byte-level shadow model against many mixed random and directed accesses.

// File: rtl/be_dmem_pkg.sv
package be_dmem_pkg;

   localparam int unsigned LANES  = 4;
   localparam int unsigned LANE_W = 8;
   localparam int unsigned WORD_W = LANES * LANE_W;

   typedef enum logic {
      SZ_WORD = 1'b0,
      SZ_BYTE = 1'b1
   } acc_size_e;

   // Big-endian: byte offset k lives in lane (LANES-1-k)
   function automatic logic [1:0] lane_of_offset(input logic [1:0] off);
      return 2'(LANES - 1) - off;
   endfunction

endpackage

// File: rtl/be_lane_decode.sv
module be_lane_decode
   import be_dmem_pkg::*;
(
   input  logic [1:0]       off_i,
   input  acc_size_e        size_i,
   input  logic             we_i,
   output logic [LANES-1:0] lane_we_o,
   output logic [1:0]       lane_sel_o,
   output logic             misalign_o
);

   logic bad_word;

   always_comb begin
      bad_word   = (size_i == SZ_WORD) && (off_i != 2'b00);
      lane_sel_o = lane_of_offset(off_i);
      lane_we_o  = '0;
      if (we_i && !bad_word) begin
         if (size_i == SZ_WORD) begin
            lane_we_o = '1;
         end else begin
            lane_we_o[lane_sel_o] = 1'b1;
         end
      end
   end

   assign misalign_o = bad_word;

endmodule

// File: rtl/be_wdata_steer.sv
module be_wdata_steer
   import be_dmem_pkg::*;
(
   input  acc_size_e         size_i,
   input  logic [WORD_W-1:0] wdata_i,
   output logic [WORD_W-1:0] lane_data_o
);

   // A byte store copies the low byte onto every lane; the lane enables pick one.
   always_comb begin
      if (size_i == SZ_BYTE) begin
         lane_data_o = {LANES{wdata_i[LANE_W-1:0]}};
      end else begin
         lane_data_o = wdata_i;
      end
   end

endmodule

// File: rtl/be_lane_ram.sv
module be_lane_ram
   import be_dmem_pkg::*;
#(
   parameter int unsigned DEPTH_WORDS = 256,
   localparam int unsigned IDX_W = $clog2(DEPTH_WORDS)
) (
   input  logic              clk_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [LANES-1:0]  lane_we_i,
   input  logic [WORD_W-1:0] lane_data_i,
   output logic [WORD_W-1:0] word_o
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] store [DEPTH_WORDS];

      always_ff @(posedge clk_i) begin
         if (lane_we_i[g]) begin
            store[idx_i] <= lane_data_i[g*LANE_W +: LANE_W];
         end
      end

      assign word_o[g*LANE_W +: LANE_W] = store[idx_i];
   end

endmodule

// File: rtl/be_rdata_format.sv
module be_rdata_format
   import be_dmem_pkg::*;
#(
   parameter bit BYTE_LOAD_SIGNED = 1'b1
) (
   input  acc_size_e         size_i,
   input  logic [1:0]        lane_sel_i,
   input  logic              misalign_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [WORD_W-1:0] rdata_o
);

   logic [LANE_W-1:0] picked;
   logic [WORD_W-1:0] byte_ext;

   assign picked = word_i[lane_sel_i*LANE_W +: LANE_W];

   if (BYTE_LOAD_SIGNED) begin : g_sext
      assign byte_ext = {{(WORD_W-LANE_W){picked[LANE_W-1]}}, picked};
   end else begin : g_zext
      assign byte_ext = {{(WORD_W-LANE_W){1'b0}}, picked};
   end

   always_comb begin
      if (misalign_i) begin
         rdata_o = '0;
      end else if (size_i == SZ_BYTE) begin
         rdata_o = byte_ext;
      end else begin
         rdata_o = word_i;
      end
   end

endmodule

// File: rtl/be_data_mem.sv
module be_data_mem
   import be_dmem_pkg::*;
#(
   parameter int unsigned ADDR_W           = 32,
   parameter int unsigned DEPTH_WORDS      = 256,
   parameter bit          BYTE_LOAD_SIGNED = 1'b1,
   localparam int unsigned IDX_W = $clog2(DEPTH_WORDS)
) (
   input  logic              clk_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              acc_byte_i,
   input  logic              we_i,
   input  logic [31:0]       wdata_i,
   output logic [31:0]       rdata_o,
   output logic              misalign_o
);

   if (DEPTH_WORDS < 2 || (1 << IDX_W) != DEPTH_WORDS) begin : g_bad_depth
      $error("DEPTH_WORDS must be a power of two of at least 2");
   end
   if (ADDR_W < IDX_W + 2) begin : g_bad_addr
      $error("ADDR_W too narrow for DEPTH_WORDS");
   end
   if (WORD_W != 32) begin : g_bad_word
      $error("word width must be 32 bits");
   end

   acc_size_e         size;
   logic [LANES-1:0]  lane_we;
   logic [1:0]        lane_sel;
   logic [WORD_W-1:0] lane_data;
   logic [WORD_W-1:0] word_rd;
   logic [IDX_W-1:0]  idx;

   assign size = acc_size_e'(acc_byte_i);
   assign idx  = addr_i[IDX_W+1:2];

   if (ADDR_W > IDX_W + 2) begin : g_alias
      logic unused_hi_bits;
      assign unused_hi_bits = ^addr_i[ADDR_W-1:IDX_W+2];
   end

   be_lane_decode i_decode (
      .off_i      (addr_i[1:0]),
      .size_i     (size),
      .we_i       (we_i),
      .lane_we_o  (lane_we),
      .lane_sel_o (lane_sel),
      .misalign_o (misalign_o)
   );

   be_wdata_steer i_steer (
      .size_i      (size),
      .wdata_i     (wdata_i),
      .lane_data_o (lane_data)
   );

   be_lane_ram #(
      .DEPTH_WORDS (DEPTH_WORDS)
   ) i_ram (
      .clk_i       (clk_i),
      .idx_i       (idx),
      .lane_we_i   (lane_we),
      .lane_data_i (lane_data),
      .word_o      (word_rd)
   );

   be_rdata_format #(
      .BYTE_LOAD_SIGNED (BYTE_LOAD_SIGNED)
   ) i_fmt (
      .size_i     (size),
      .lane_sel_i (lane_sel),
      .misalign_i (misalign_o),
      .word_i     (word_rd),
      .rdata_o    (rdata_o)
   );

endmodule

// File: rtl/be_data_mem_chk.sv
module be_data_mem_chk #(
   parameter int unsigned ADDR_W           = 32,
   parameter bit          BYTE_LOAD_SIGNED = 1'b1
) (
   input logic              clk_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic              acc_byte_i,
   input logic              we_i,
   input logic [31:0]       wdata_i,
   input logic [31:0]       rdata_o,
   input logic              misalign_o,
   input logic [3:0]        lane_we
);

   logic armed = 1'b0;
   always @(posedge clk_i) armed <= 1'b1;

   AST_MISALIGN_READS_ZERO: assert property (@(posedge clk_i) disable iff (!armed)
      misalign_o |-> rdata_o == 32'd0); // R7

   AST_MISALIGN_NO_WRITE: assert property (@(posedge clk_i) disable iff (!armed)
      misalign_o |-> lane_we == 4'b0000); // R6

   AST_BYTE_NEVER_MISALIGN: assert property (@(posedge clk_i) disable iff (!armed)
      acc_byte_i |-> !misalign_o); // R5

   AST_MISALIGN_NEEDS_OFFSET: assert property (@(posedge clk_i) disable iff (!armed)
      misalign_o |-> (addr_i[1:0] != 2'b00)); // R5

   AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!armed)
      !we_i |-> lane_we == 4'b0000); // R10

   AST_BYTE_LOAD_EXTEND: assert property (@(posedge clk_i) disable iff (!armed)
      (acc_byte_i && BYTE_LOAD_SIGNED) |-> rdata_o[31:8] == {24{rdata_o[7]}}); // R3

   AST_WORD_READBACK: assert property (@(posedge clk_i) disable iff (!armed)
      (we_i && !acc_byte_i && addr_i[1:0] == 2'b00)
      ##1 (!acc_byte_i && addr_i == $past(addr_i))
      |-> rdata_o == $past(wdata_i)); // R1

endmodule

bind be_data_mem be_data_mem_chk #(
   .ADDR_W           (ADDR_W),
   .BYTE_LOAD_SIGNED (BYTE_LOAD_SIGNED)
) i_be_data_mem_chk (
   .clk_i      (clk_i),
   .addr_i     (addr_i),
   .acc_byte_i (acc_byte_i),
   .we_i       (we_i),
   .wdata_i    (wdata_i),
   .rdata_o    (rdata_o),
   .misalign_o (misalign_o),
   .lane_we    (lane_we)
);

// File: tb/test_be_data_mem.sv
module test_be_data_mem;

   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned DEPTH      = 256;
   localparam int unsigned BYTES      = DEPTH * 4;
   localparam int unsigned N_RANDOM   = 3000;

   logic        clk = 1'b0;
   logic [31:0] addr = '0;
   logic        acc_byte = 1'b0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        misalign;

   logic [7:0]  model [BYTES];
   int unsigned n_checks = 0;
   int unsigned n_fail   = 0;
   bit          done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   be_data_mem #(.ADDR_W(32), .DEPTH_WORDS(DEPTH)) i_be_data_mem (
      .clk_i      (clk),
      .addr_i     (addr),
      .acc_byte_i (acc_byte),
      .we_i       (we),
      .wdata_i    (wdata),
      .rdata_o    (rdata),
      .misalign_o (misalign)
   );

   function automatic int unsigned bidx(input logic [31:0] a);
      return int'(a) % BYTES;
   endfunction

   function automatic logic exp_mis(input logic [31:0] a, input logic b);
      return !b && (a[1:0] != 2'b00);
   endfunction

   function automatic logic [31:0] exp_rd(input logic [31:0] a, input logic b);
      int unsigned base;
      if (exp_mis(a, b)) return 32'd0;
      if (b) return {{24{model[bidx(a)][7]}}, model[bidx(a)]};
      base = bidx(a);
      return {model[base], model[base+1], model[base+2], model[base+3]};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   // One access: drive after a falling edge, check the combinational read, then commit.
   task automatic access(input logic [31:0] a, input logic b, input logic w,
                         input logic [31:0] d, input string req);
      @(negedge clk);
      addr = a; acc_byte = b; we = w; wdata = d;
      #2;
      check({req, " rdata"}, rdata, exp_rd(a, b));
      check({req, " misalign"}, {31'd0, misalign}, {31'd0, exp_mis(a, b)});
      @(posedge clk);
      if (w && !exp_mis(a, b)) begin
         if (b) model[bidx(a)] = d[7:0];
         else for (int k = 0; k < 4; k++) model[bidx(a)+k] = d[31-8*k -: 8];
      end
      #1;
      we = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] a, d;
      int unsigned seed_sink;
      seed_sink = $urandom(32'd20250);
      for (int i = 0; i < BYTES; i++) model[i] = 8'h00;

      // Quiet idle state: word access at address 0 with no write
      #1;
      check("R5 idle misalign", {31'd0, misalign}, 32'd0);

      // Clear every word (R1)
      for (int i = 0; i < DEPTH; i++) begin
         @(negedge clk);
         addr = 32'(i * 4); acc_byte = 1'b0; we = 1'b1; wdata = 32'd0;
         @(posedge clk); #1;
      end
      we = 1'b0;

      // R1 / R2: big-endian word then per-byte reads
      access(32'h10, 1'b0, 1'b1, 32'h11223344, "R1 store");
      access(32'h10, 1'b0, 1'b0, 32'h0, "R1 load");
      check("R1 word", rdata, 32'h11223344);
      access(32'h10, 1'b1, 1'b0, 32'h0, "R2 off0");
      check("R2 off0 value", rdata, 32'h00000011);
      access(32'h13, 1'b1, 1'b0, 32'h0, "R2 off3");
      check("R2 off3 value", rdata, 32'h00000044);

      // R4 / R3: byte store into offset 1, negative byte
      access(32'h11, 1'b1, 1'b1, 32'hABCDEF80, "R4 store");
      access(32'h10, 1'b0, 1'b0, 32'h0, "R4 neighbours");
      check("R4 word", rdata, 32'h11803344);
      access(32'h11, 1'b1, 1'b0, 32'h0, "R3 sign");
      check("R3 value", rdata, 32'hFFFFFF80);

      // R5 / R6 / R7: misaligned word store
      access(32'h12, 1'b0, 1'b1, 32'hDEADBEEF, "R7 misaligned");
      check("R7 zero", rdata, 32'd0);
      check("R5 flag", {31'd0, misalign}, 32'd1);
      access(32'h10, 1'b0, 1'b0, 32'h0, "R6 intact");
      check("R6 word", rdata, 32'h11803344);

      // R10: disabled write
      access(32'h10, 1'b0, 1'b0, 32'h55555555, "R10 nowrite");
      access(32'h10, 1'b0, 1'b0, 32'h0, "R10 intact");
      check("R10 word", rdata, 32'h11803344);

      // R9: aliasing through high address bits
      access(32'h10 + BYTES * 3, 1'b0, 1'b0, 32'h0, "R9 alias");
      check("R9 word", rdata, 32'h11803344);

      // R8: same-cycle read sees old value, next cycle the new one
      @(negedge clk);
      addr = 32'h20; acc_byte = 1'b0; we = 1'b1; wdata = 32'hCAFEF00D;
      #2;
      check("R8 before edge", rdata, 32'h00000000);
      @(posedge clk); #1;
      we = 1'b0;
      for (int k = 0; k < 4; k++) model[32'h20 + k] = wdata[31-8*k -: 8];
      check("R8 after edge", rdata, 32'hCAFEF00D);

      // Constrained random mix (R1..R10)
      for (int i = 0; i < N_RANDOM; i++) begin
         a = $urandom_range(BYTES * 4 - 1);
         if ($urandom_range(3) != 0 && ($urandom_range(1) == 0)) a[1:0] = 2'b00;
         d = $urandom;
         access(a, 1'($urandom_range(1)), 1'($urandom_range(1)), d, "R2 random");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule